// File: doc/BRIEF.md
# Memory Stage Sequencer

This block is the data-memory step of a short in-order pipeline that runs four kinds of operation: ALU, load, store and branch. The execute step hands it one operation at a time through a request/acknowledge pair. The operation carries the kind, a destination register index, store data, a memory address and an ALU result. The sequencer then runs a short, kind-specific exchange on up to three outgoing channels: a data-memory read channel, a data-memory write channel and a write-back channel.

Every outgoing channel works the same way. The sequencer raises a level request together with a payload that holds still. The partner answers with a one-cycle acknowledge. An acknowledge that arrives while the matching request is low has no effect.

ALU and load results must reach the register file before any later operation reads it. For this reason the block drives a pending flag that a hazard detector watches. The flag is raised when an ALU or load operation is taken. It stays up through the gap between releasing execute and the write-back handshake, and it drops when write-back acknowledges. Stores never touch write-back and never raise the flag.

Top module: `mem_stage_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the pending flag and the read, write and write-back requests are all low, and `ex_ack` is low.
- R2: An operation is taken, and `ex_ack` is high, in a cycle only when `ex_req` is high, the pending flag is low and the write request is low. Each taken operation produces exactly one `ex_ack` cycle.
- R3: ALU operation (kind 0): the cycle after it is taken, the pending flag and `wb_req` are high, with `wb_kind`=0, `wb_dst` equal to the destination and `wb_val` equal to the ALU result.
- R4: Load operation (kind 1): the cycle after it is taken, the pending flag and `rd_req` are high, `rd_addr` equals the address and `wb_req` is low. The cycle after `rd_ack`, `rd_req` is low and `wb_req` is high, with `wb_kind`=1 and `wb_val` equal to the `rd_data` sampled with that acknowledge.
- R5: Store operation (kind 2): the cycle after it is taken, `wr_req` is high, with `wr_addr` and `wr_data` equal to the address and store data. The pending flag stays low and no write-back request follows.
- R6: The cycle after `wb_ack` is seen with `wb_req` high, both `wb_req` and the pending flag are low.
- R7: While `wb_req` is high and not acknowledged, `wb_req` stays high and its kind, destination and value do not change.
- R8: `rd_req` and `wr_req` each stay high, with a steady address and data, until their acknowledge.
- R9: An acknowledge on a channel whose request is low changes nothing. In particular, a stray `wb_ack` while a load waits for memory leaves the pending flag high.
- R10: Branch operation (kind 3): it is acknowledged to execute, but it raises no channel and leaves the pending flag low.
- R11: While the pending flag or `wr_req` is high, a waiting `ex_req` is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_req | input | 1 | Operation offered by execute |
| ex_kind | input | 2 | 0 ALU, 1 load, 2 store, 3 branch |
| ex_dst | input | DST_W | Destination register index |
| ex_sdata | input | DATA_W | Store data |
| ex_addr | input | ADDR_W | Data-memory address |
| ex_alu | input | DATA_W | ALU result |
| ex_ack | output | 1 | Operation taken this cycle |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge, one cycle |
| rd_data | input | DATA_W | Read data, valid with `rd_ack` |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_ack | input | 1 | Write acknowledge, one cycle |
| wb_req | output | 1 | Write-back request |
| wb_kind | output | 2 | Kind of the result being written back |
| wb_dst | output | DST_W | Destination register index |
| wb_val | output | DATA_W | Value to write |
| wb_ack | input | 1 | Write-back acknowledge, one cycle |
| wr_pend | output | 1 | Register write still in flight |

## Verification
The bench builds the block with DATA_W=32, ADDR_W=8 and DST_W=3. With an 8-bit address, a 256-word memory model in the bench can cover the whole address space. The bench then keeps stores and loads inside sixteen words, so later loads often read back words written by earlier stores, and the returned data can be checked against a shadow copy. The three-bit destination keeps register indices in a small range. Acknowledge delays of zero to three cycles on each channel reach the back-to-back case, as well as stalls behind a slow write or a slow write-back.

// File: rtl/ms_pkg.sv
package ms_pkg;

  typedef enum logic [1:0] {
    OP_ALU    = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_BRANCH = 2'd3
  } op_kind_e;

  // Operations whose result must reach the register file
  function automatic logic writes_reg(input logic [1:0] k);
    return (k == OP_ALU) || (k == OP_LOAD);
  endfunction

  // Operations that need a data-memory read before write-back
  function automatic logic reads_mem(input logic [1:0] k);
    return k == OP_LOAD;
  endfunction

  // Operations that only write data memory
  function automatic logic writes_mem(input logic [1:0] k);
    return k == OP_STORE;
  endfunction

  // Operations that can go to write-back straight away
  function automatic logic result_ready(input logic [1:0] k);
    return k == OP_ALU;
  endfunction

endpackage

// File: rtl/ms_accept.sv
module ms_accept
  import ms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ex_req,
  input  logic [1:0] ex_kind,
  input  logic       pend,
  input  logic       wr_busy,
  output logic       take,
  output logic       go_alu,
  output logic       go_load,
  output logic       go_store,
  output logic       go_drop
);

  logic gate_open;

  always_comb begin
    gate_open = !pend && !wr_busy;
    take      = ex_req && gate_open;
    go_alu    = take && result_ready(ex_kind);
    go_load   = take && reads_mem(ex_kind);
    go_store  = take && writes_mem(ex_kind);
    go_drop   = take && !writes_reg(ex_kind) && !writes_mem(ex_kind);
  end

  // Each taken operation falls into exactly one path (R2)
  assert_one_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $countones({go_alu, go_load, go_store, go_drop}) == 1);

  assert_paths_need_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_alu, go_load, go_store, go_drop}));

endmodule

// File: rtl/ms_req_chan.sv
module ms_req_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic req,
  output logic done
);

  assign done = req && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    req <= 1'b0;
    else if (set)  req <= 1'b1;
    else if (done) req <= 1'b0;
  end

  // A request waits for its own acknowledge (R8, R7)
  assert_req_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);

  // A channel is never restarted while still busy (R2)
  assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set |-> !req);

  // Acknowledge with request low leaves channel idle (R9)
  assert_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !set && ack) |=> !req);

endmodule

// File: rtl/ms_wb_path.sv
module ms_wb_path #(
  parameter int DATA_W = 32,
  parameter int DST_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_alu,
  input  logic              take_load,
  input  logic [1:0]        kind_in,
  input  logic [DST_W-1:0]  dst_in,
  input  logic [DATA_W-1:0] alu_in,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wb_ack,
  output logic              wb_req,
  output logic [1:0]        wb_kind,
  output logic [DST_W-1:0]  wb_dst,
  output logic [DATA_W-1:0] wb_val,
  output logic              pend
);

  logic wb_set;
  logic wb_done;
  logic pend_set;

  assign wb_set   = take_alu || rd_done;
  assign pend_set = take_alu || take_load;

  ms_req_chan u_wb_chan (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wb_set),
    .ack   (wb_ack),
    .req   (wb_req),
    .done  (wb_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (pend_set) pend <= 1'b1;
    else if (wb_done)  pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_kind <= '0;
      wb_dst  <= '0;
      wb_val  <= '0;
    end else begin
      if (pend_set) begin
        wb_kind <= kind_in;
        wb_dst  <= dst_in;
      end
      if (take_alu)     wb_val <= alu_in;
      else if (rd_done) wb_val <= rd_data;
    end
  end

  // Write-back payload steady while waiting (R7)
  assert_wb_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_val) && $stable(wb_dst)
                             && $stable(wb_kind)));

  // Pending drops right after the write-back handshake (R6)
  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack) |=> (!pend && !wb_req));

  // Stray write-back acknowledge keeps pending (R9)
  assert_pend_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !wb_req && wb_ack) |=> pend);

endmodule

// File: rtl/mem_stage_seq.sv
module mem_stage_seq
  import ms_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int DST_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_req,
  input  logic [1:0]        ex_kind,
  input  logic [DST_W-1:0]  ex_dst,
  input  logic [DATA_W-1:0] ex_sdata,
  input  logic [ADDR_W-1:0] ex_addr,
  input  logic [DATA_W-1:0] ex_alu,
  output logic              ex_ack,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              wb_req,
  output logic [1:0]        wb_kind,
  output logic [DST_W-1:0]  wb_dst,
  output logic [DATA_W-1:0] wb_val,
  input  logic              wb_ack,
  output logic              wr_pend
);

  logic take, go_alu, go_load, go_store, go_drop;
  logic rd_done, wr_done;
  logic pend;

  ms_accept u_accept (
    .clk      (clk),
    .rst_n    (rst_n),
    .ex_req   (ex_req),
    .ex_kind  (ex_kind),
    .pend     (pend),
    .wr_busy  (wr_req),
    .take     (take),
    .go_alu   (go_alu),
    .go_load  (go_load),
    .go_store (go_store),
    .go_drop  (go_drop)
  );

  ms_req_chan u_rd_chan (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (go_load),
    .ack   (rd_ack),
    .req   (rd_req),
    .done  (rd_done)
  );

  ms_req_chan u_wr_chan (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (go_store),
    .ack   (wr_ack),
    .req   (wr_req),
    .done  (wr_done)
  );

  ms_wb_path #(.DATA_W(DATA_W), .DST_W(DST_W)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_alu  (go_alu),
    .take_load (go_load),
    .kind_in   (ex_kind),
    .dst_in    (ex_dst),
    .alu_in    (ex_alu),
    .rd_done   (rd_done),
    .rd_data   (rd_data),
    .wb_ack    (wb_ack),
    .wb_req    (wb_req),
    .wb_kind   (wb_kind),
    .wb_dst    (wb_dst),
    .wb_val    (wb_val),
    .pend      (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      if (go_load)  rd_addr <= ex_addr;
      if (go_store) begin
        wr_addr <= ex_addr;
        wr_data <= ex_sdata;
      end
    end
  end

  assign ex_ack  = take;
  assign wr_pend = pend;

  // Read in flight implies a pending register write (R4)
  assert_rd_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> pend);

  // Write-back request always covered by pending (R3)
  assert_wb_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> pend);

  // Stores never overlap a pending register write (R5)
  assert_store_no_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !pend);

  // Pending only rises after an accept (R2)
  assert_pend_from_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(ex_ack));

  // Busy stage holds execute off (R11)
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend || wr_req) |-> !ex_ack);

  // Read and write payloads steady while waiting (R8)
  assert_rd_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> $stable(rd_addr));
  assert_wr_payload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> ($stable(wr_addr) && $stable(wr_data)));

  // Branch raises no channel (R10)
  assert_drop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go_drop |=> (!rd_req && !wr_req && !wb_req && !pend));

  // Channel finished: load result goes on to write-back (R4)
  assert_load_to_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (wb_req && !rd_req));

  assert_wr_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_req);

endmodule

// File: tb/tb_mem_stage_seq.sv
module tb_mem_stage_seq;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int DST_W  = 3;
  localparam int MEM_N  = 1 << ADDR_W;

  typedef struct packed {
    logic [1:0]        kind;
    logic [DST_W-1:0]  dst;
    logic [DATA_W-1:0] val;
  } wb_item_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              ex_req = 1'b0;
  logic [1:0]        ex_kind = '0;
  logic [DST_W-1:0]  ex_dst = '0;
  logic [DATA_W-1:0] ex_sdata = '0;
  logic [ADDR_W-1:0] ex_addr = '0;
  logic [DATA_W-1:0] ex_alu = '0;
  logic              ex_ack;
  logic              rd_req, wr_req, wb_req, wr_pend;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] wr_data, wb_val;
  logic [DATA_W-1:0] rd_data_r = '0;
  logic [1:0]        wb_kind;
  logic [DST_W-1:0]  wb_dst;
  logic rd_ack_r = 1'b0, wr_ack_r = 1'b0, wb_ack_r = 1'b0, stray = 1'b0;
  logic wb_ack_w;
  assign wb_ack_w = wb_ack_r | stray;

  mem_stage_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DST_W(DST_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ex_req(ex_req), .ex_kind(ex_kind), .ex_dst(ex_dst), .ex_sdata(ex_sdata),
    .ex_addr(ex_addr), .ex_alu(ex_alu), .ex_ack(ex_ack),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack_r), .rd_data(rd_data_r),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack_r),
    .wb_req(wb_req), .wb_kind(wb_kind), .wb_dst(wb_dst), .wb_val(wb_val),
    .wb_ack(wb_ack_w), .wr_pend(wr_pend)
  );

  int checks = 0;
  int fails  = 0;
  int rd_dly = 0, wr_dly = 0, wb_dly = 0;
  int rd_cnt = 0, wr_cnt = 0, wb_cnt = 0;
  int cyc = 0;

  logic [DATA_W-1:0] mem    [MEM_N];
  logic [DATA_W-1:0] shadow [MEM_N];

  wb_item_t          wb_q[$];
  wr_item_t          wr_q[$];
  logic [ADDR_W-1:0] rd_q[$];

  task automatic check(input string req, input logic ok,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: offer one operation and record what it must produce
  task automatic drive(input logic [1:0] k, input logic [DST_W-1:0] d,
                       input logic [DATA_W-1:0] sd, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] alu);
    wb_item_t w;
    wr_item_t s;
    ex_req = 1'b1; ex_kind = k; ex_dst = d; ex_sdata = sd; ex_addr = a; ex_alu = alu;
    case (k)
      2'd0: begin w.kind = k; w.dst = d; w.val = alu; wb_q.push_back(w); end
      2'd1: begin
        rd_q.push_back(a);
        w.kind = k; w.dst = d; w.val = shadow[a]; wb_q.push_back(w);
      end
      2'd2: begin s.addr = a; s.data = sd; wr_q.push_back(s); shadow[a] = sd; end
      default: ;
    endcase
  endtask

  task automatic wait_ack();
    forever begin
      #1;
      if (ex_ack) break;
      @(negedge clk);
    end
    @(negedge clk);
    ex_req = 1'b0;
  endtask

  task automatic drain();
    while (wb_q.size() != 0 || wr_q.size() != 0 || rd_q.size() != 0
           || wb_req || rd_req || wr_req)
      @(negedge clk);
    @(negedge clk);
  endtask

  // Monitors / responders on the three outgoing channels
  always @(negedge clk) begin
    if (rd_ack_r) rd_ack_r = 1'b0;
    else if (rd_req) begin
      if (rd_cnt >= rd_dly) begin
        if (rd_q.size() == 0) check("R4 unexpected read", 1'b0, DATA_W'(rd_addr), '0);
        else begin
          logic [ADDR_W-1:0] ea;
          ea = rd_q.pop_front();
          check("R4 read address", rd_addr == ea, DATA_W'(rd_addr), DATA_W'(ea));
        end
        rd_data_r = mem[rd_addr];
        rd_ack_r = 1'b1; rd_cnt = 0;
      end else rd_cnt++;
    end
  end

  always @(negedge clk) begin
    if (wr_ack_r) wr_ack_r = 1'b0;
    else if (wr_req) begin
      if (wr_cnt >= wr_dly) begin
        if (wr_q.size() == 0) check("R5 unexpected write", 1'b0, DATA_W'(wr_addr), '0);
        else begin
          wr_item_t e;
          e = wr_q.pop_front();
          check("R5 write address", wr_addr == e.addr, DATA_W'(wr_addr), DATA_W'(e.addr));
          check("R5 write data", wr_data == e.data, wr_data, e.data);
        end
        mem[wr_addr] = wr_data;
        wr_ack_r = 1'b1; wr_cnt = 0;
      end else wr_cnt++;
    end
  end

  always @(negedge clk) begin
    if (wb_ack_r) wb_ack_r = 1'b0;
    else if (wb_req) begin
      if (wb_cnt >= wb_dly) begin
        if (wb_q.size() == 0) check("R5/R10 unexpected write-back", 1'b0, wb_val, '0);
        else begin
          wb_item_t e;
          e = wb_q.pop_front();
          check("R3/R4 wb kind", wb_kind == e.kind, DATA_W'(wb_kind), DATA_W'(e.kind));
          check("R3/R4 wb dst", wb_dst == e.dst, DATA_W'(wb_dst), DATA_W'(e.dst));
          check("R3/R4 wb value", wb_val == e.val, wb_val, e.val);
        end
        wb_ack_r = 1'b1; wb_cnt = 0;
      end else wb_cnt++;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i]    = 32'h5A00_0000 ^ (i * 32'h0001_0203);
      shadow[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset idle", !wr_pend && !rd_req && !wr_req && !wb_req && !ex_ack,
          {27'd0, wr_pend, rd_req, wr_req, wb_req, ex_ack}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", !wr_pend && !rd_req && !wr_req && !wb_req,
          {28'd0, wr_pend, rd_req, wr_req, wb_req}, '0);

    // R3 / R7 / R6: ALU with slow write-back
    wb_dly = 3;
    drive(2'd0, 3'd5, '0, 8'd0, 32'hCAFE_0001);
    wait_ack();
    check("R3 pend after alu", wr_pend == 1'b1, DATA_W'(wr_pend), 1);
    check("R3 wb_req after alu", wb_req == 1'b1, DATA_W'(wb_req), 1);
    check("R3 wb value", wb_val == 32'hCAFE_0001, wb_val, 32'hCAFE_0001);
    @(negedge clk); @(negedge clk);
    check("R7 wb value held", wb_req && wb_val == 32'hCAFE_0001, wb_val, 32'hCAFE_0001);
    while (wb_req) @(negedge clk);
    check("R6 pend cleared with wb", wr_pend == 1'b0, DATA_W'(wr_pend), 0);

    // R4 / R9: load with slow memory and a stray write-back acknowledge
    rd_dly = 3; wb_dly = 0;
    drive(2'd1, 3'd2, '0, 8'd7, '0);
    wait_ack();
    check("R4 rd_req after load", rd_req == 1'b1, DATA_W'(rd_req), 1);
    check("R4 rd_addr", rd_addr == 8'd7, DATA_W'(rd_addr), 7);
    check("R4 pend, no wb yet", wr_pend && !wb_req, {30'd0, wr_pend, wb_req}, 2);
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    check("R9 stray wb_ack ignored", wr_pend && !wb_req, {30'd0, wr_pend, wb_req}, 2);
    drain();

    // R5 / R8 / R11: store with slow write, then ALU waiting behind it
    wr_dly = 3;
    drive(2'd2, 3'd0, 32'h1234_5678, 8'd9, '0);
    wait_ack();
    check("R5 wr_req after store", wr_req == 1'b1, DATA_W'(wr_req), 1);
    check("R5 no pend for store", wr_pend == 1'b0, DATA_W'(wr_pend), 0);
    drive(2'd0, 3'd1, '0, '0, 32'h0000_BEEF);
    #1;
    check("R11 held off during write", ex_ack == 1'b0, DATA_W'(ex_ack), 0);
    @(negedge clk);
    check("R8 wr_req held", wr_req == 1'b1 && wr_data == 32'h1234_5678, wr_data, 32'h1234_5678);
    wait_ack();
    drain();

    // R4 with data from an earlier store
    rd_dly = 0; wr_dly = 0;
    drive(2'd1, 3'd3, '0, 8'd9, '0);
    wait_ack();
    drain();

    // R10: branch is acknowledged and dropped
    drive(2'd3, 3'd4, 32'hFFFF_FFFF, 8'd1, 32'hFFFF_FFFF);
    wait_ack();
    check("R10 branch quiet", !rd_req && !wr_req && !wb_req && !wr_pend,
          {28'd0, rd_req, wr_req, wb_req, wr_pend}, '0);

    // R2: random stream, each operation acknowledged once and in order
    for (int n = 0; n < 60; n++) begin
      rd_dly = $urandom_range(0, 3);
      wr_dly = $urandom_range(0, 3);
      wb_dly = $urandom_range(0, 3);
      drive(2'($urandom_range(0, 3)), DST_W'($urandom), $urandom,
            ADDR_W'($urandom_range(0, 15)), $urandom);
      wait_ack();
    end
    drain();
    check("R2 all expectations consumed", wb_q.size() == 0 && wr_q.size() == 0
          && rd_q.size() == 0, DATA_W'(wb_q.size() + wr_q.size() + rd_q.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule